// File: doc/BRIEF.md
# NAND Flash Device Bus Front-End

This block sits on the device side of an 8-bit asynchronous flash bus and runs on a system clock. It passes the bus strobes through synchronizers and then detects their edges. A write strobe edge moves the bus byte into one of three places: the command register, a three-byte address register, or a data-input port. The CLE and ALE levels pick the place. A read strobe edge places a byte on the output bus and advances a column counter. The byte comes either from an external data source, which is indexed by that counter, or from a status byte.

Busy time stands in for the missing array. Confirming a read, program or erase loads a counter with a per-operation cycle count, and R/B# stays low until that counter reaches zero. The block also tracks standby. Deselecting the chip while it is idle drops it to standby and ends any read in progress. Deselecting it while it is busy has no effect. A low write-protect level blocks program and erase.

Top module: `nand_bus_frontend`

## Requirements
- R1: After reset, rb_n_o is 1, io_oe_o is 0, cmd_o, addr_o and col_o are 0, din_valid_o is 0, and standby_o is 1 while ce_n_i is high.
- R2: A rising edge of we_n_i with cle_i high and ce_n_i low loads io_i into cmd_o. Each strobe edge acts exactly once.
- R3: Write strobes with ale_i high and cle_i low fill addr_o in this order: column into bits 7:0, row low into bits 15:8, row high into bits 23:16. The column byte also loads col_o. Address writes after the third are ignored. Any command write restarts the count at the column byte.
- R4: In program setup (command 0x80), a write with cle_i and ale_i both low gives one din_valid_o pulse carrying the byte on din_o, and col_o then advances by one.
- R5: After read setup 0x00, address and confirm 0x30, with the block not busy, each falling edge of re_n_i outputs rd_data_i for the current col_o and then increments col_o.
- R6: io_oe_o is 1 only while ce_n_i is low, re_n_i is low and a read or status mode is active.
- R7: A rising edge of ce_n_i while not busy ends the read mode, so a later read strobe leaves io_oe_o at 0. standby_o is 1 while ce_n_i is high and the block is not busy.
- R8: A rising edge of ce_n_i while busy is ignored: standby_o stays 0 and rb_n_o stays 0 until the operation ends.
- R9: Confirm codes start busy: 0x30 after 0x00, 0x10 after 0x80, and 0xD0 after 0x60. rb_n_o is then low for exactly BUSY_RD, BUSY_PG or BUSY_ER cycles.
- R10: While busy, every write strobe is ignored except the status command 0x70, which loads cmd_o and selects status output.
- R11: In status mode a read strobe returns a byte with bit 7 equal to wp_n_i, bit 6 equal to 1 when ready, and all other bits 0.
- R12: With wp_n_i low, a program or erase confirm starts no busy period. Driving wp_n_i low during a program or erase busy period ends it.
- R13: Write strobes while ce_n_i is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip select, active low |
| cle_i | input | 1 | Command strobe qualifier |
| ale_i | input | 1 | Address strobe qualifier |
| we_n_i | input | 1 | Write strobe, active low |
| re_n_i | input | 1 | Read strobe, active low |
| wp_n_i | input | 1 | Write protect, active low |
| io_i | input | 8 | Bus byte in |
| io_o | output | 8 | Bus byte out |
| io_oe_o | output | 1 | Output enable for io_o |
| rb_n_o | output | 1 | Ready/busy, low while busy, always driven |
| standby_o | output | 1 | Deselected and idle |
| cmd_o | output | 8 | Last accepted command |
| addr_o | output | 24 | Captured address bytes |
| col_o | output | 8 | Column counter, index for rd_data_i |
| rd_data_i | input | 8 | Data source byte at col_o |
| din_o | output | 8 | Program data byte |
| din_valid_o | output | 1 | One-cycle strobe for din_o |

## Verification
The write path is tried with every CLE/ALE routing, with a fourth address byte, and with a command that interrupts the address sequence. Together these separate byte order, the saturation of the address count and the restart of that count. Reads from the array are compared byte by byte against a data source that depends on the column, which exposes a missed or doubled column increment. Status reads are taken while busy, when ready, and with write protect at both levels, so a swapped status bit shows up. Deselection is tried once while idle and once inside an erase. The last test separates an early standby from the protected busy state. The program sequence is run with write protect low at confirm and again with write protect going low mid-operation.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {OUT_OFF, OUT_ARRAY, OUT_STATUS} out_e;
endpackage

// File: rtl/nand_sync.sv
module nand_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/nand_edge.sv
module nand_edge #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] p_o
);
  nand_sync #(.W(W), .RST_VAL(RST_VAL)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .q_o   (q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= RST_VAL;
    else         p_o <= q_o;
  end
endmodule

// File: rtl/nand_addr.sv
module nand_addr #(
  parameter  int DW   = 8,
  parameter  int NCYC = 3,
  localparam int CW   = $clog2(NCYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic              inc_i,
  input  logic [DW-1:0]     byte_i,
  output logic [DW*NCYC-1:0] addr_o,
  output logic [DW-1:0]     col_o,
  output logic [CW-1:0]     cnt_o
);
  logic [DW-1:0] byte_q [NCYC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      col_o <= '0;
      for (int i = 0; i < NCYC; i++) byte_q[i] <= '0;
    end else begin
      if (clr_i) cnt_o <= '0;
      else if (ld_i && cnt_o != CW'(NCYC)) cnt_o <= cnt_o + 1'b1;
      if (ld_i) begin
        for (int i = 0; i < NCYC; i++)
          if (cnt_o == CW'(i)) byte_q[i] <= byte_i;
      end
      // first address cycle seeds the column counter
      if (ld_i && cnt_o == '0) col_o <= byte_i;
      else if (inc_i)          col_o <= col_o + 1'b1;
    end
  end

  for (genvar g = 0; g < NCYC; g++) begin : g_addr
    assign addr_o[g*DW +: DW] = byte_q[g];
  end
endmodule

// File: rtl/nand_busy.sv
module nand_busy import nand_fe_pkg::*; #(
  parameter  int RD_CYC = 20,
  parameter  int PG_CYC = 60,
  parameter  int ER_CYC = 120,
  localparam int MX1    = (RD_CYC > PG_CYC) ? RD_CYC : PG_CYC,
  localparam int MX     = (MX1 > ER_CYC) ? MX1 : ER_CYC,
  localparam int CW     = $clog2(MX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  input  logic abort_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q, len;
  op_e           op_q;

  always_comb begin
    case (op_i)
      OP_READ:  len = CW'(RD_CYC);
      OP_PROG:  len = CW'(PG_CYC);
      OP_ERASE: len = CW'(ER_CYC);
      default:  len = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= OP_NONE;
    end else if (start_i) begin
      cnt_q <= len;
      op_q  <= op_i;
    end else if (abort_i && (op_q == OP_PROG || op_q == OP_ERASE)) begin
      cnt_q <= '0;
      op_q  <= OP_NONE;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend import nand_fe_pkg::*; #(
  parameter  int DW       = 8,
  parameter  int ADDR_CYC = 3,
  parameter  int BUSY_RD  = 20,
  parameter  int BUSY_PG  = 60,
  parameter  int BUSY_ER  = 120,
  localparam int AW       = DW * ADDR_CYC,
  localparam int ACW      = $clog2(ADDR_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          cle_i,
  input  logic          ale_i,
  input  logic          we_n_i,
  input  logic          re_n_i,
  input  logic          wp_n_i,
  input  logic [DW-1:0] io_i,
  output logic [DW-1:0] io_o,
  output logic          io_oe_o,
  output logic          rb_n_o,
  output logic          standby_o,
  output logic [DW-1:0] cmd_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] col_o,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] din_o,
  output logic          din_valid_o
);
  logic ce_n_s, ce_n_p, we_n_s, we_n_p, re_n_s, re_n_p;
  logic cle_s, ale_s, wp_n_s;
  logic [DW-1:0] io_s;
  logic [ACW-1:0] addr_cnt;

  nand_edge #(.W(3), .RST_VAL(3'b111)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({re_n_i, we_n_i, ce_n_i}),
    .q_o   ({re_n_s, we_n_s, ce_n_s}),
    .p_o   ({re_n_p, we_n_p, ce_n_p})
  );

  nand_sync #(.W(3), .RST_VAL(3'b100)) i_lvl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wp_n_i, ale_i, cle_i}),
    .q_o   ({wp_n_s, ale_s, cle_s})
  );

  nand_sync #(.W(DW), .RST_VAL('0)) i_io (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (io_i),
    .q_o   (io_s)
  );

  logic we_rise, re_fall, ce_rise, wr_ok, busy;
  logic cmd_wr, adr_wr, dat_wr, rd_arr, go;
  op_e  pend_q, go_op;
  out_e out_q;
  logic [DW-1:0] status;

  assign we_rise = we_n_s & ~we_n_p;
  assign re_fall = ~re_n_s & re_n_p;
  assign ce_rise = ce_n_s & ~ce_n_p;
  assign wr_ok   = we_rise & ~ce_n_s;

  // while busy only the status command gets through
  assign cmd_wr = wr_ok & cle_s & (~busy | (io_s == CMD_STATUS));
  assign adr_wr = wr_ok & ~cle_s & ale_s & ~busy;
  assign dat_wr = wr_ok & ~cle_s & ~ale_s & ~busy & (pend_q == OP_PROG);
  assign rd_arr = re_fall & ~ce_n_s & ~busy & (out_q == OUT_ARRAY);

  always_comb begin
    status        = '0;
    status[DW-1]  = wp_n_s;
    status[DW-2]  = ~busy;
  end

  always_comb begin
    go    = 1'b0;
    go_op = OP_NONE;
    if (cmd_wr) begin
      case (io_s)
        CMD_RD_GO: if (pend_q == OP_READ) begin
          go = 1'b1; go_op = OP_READ;
        end
        CMD_PG_GO: if (pend_q == OP_PROG && wp_n_s) begin
          go = 1'b1; go_op = OP_PROG;
        end
        CMD_ER_GO: if (pend_q == OP_ERASE && wp_n_s) begin
          go = 1'b1; go_op = OP_ERASE;
        end
        default: ;
      endcase
    end
  end

  nand_addr #(.DW(DW), .NCYC(ADDR_CYC)) i_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cmd_wr),
    .ld_i  (adr_wr),
    .inc_i (rd_arr | dat_wr),
    .byte_i(io_s),
    .addr_o(addr_o),
    .col_o (col_o),
    .cnt_o (addr_cnt)
  );

  nand_busy #(.RD_CYC(BUSY_RD), .PG_CYC(BUSY_PG), .ER_CYC(BUSY_ER)) i_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(go),
    .op_i   (go_op),
    .abort_i(~wp_n_s),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= '0;
      pend_q      <= OP_NONE;
      out_q       <= OUT_OFF;
      io_o        <= '0;
      din_o       <= '0;
      din_valid_o <= 1'b0;
    end else begin
      din_valid_o <= dat_wr;
      if (dat_wr) din_o <= io_s;
      if (cmd_wr) begin
        cmd_o <= io_s;
        case (io_s)
          CMD_RD_SETUP: begin pend_q <= OP_READ;  out_q <= OUT_OFF; end
          CMD_PG_SETUP: begin pend_q <= OP_PROG;  out_q <= OUT_OFF; end
          CMD_ER_SETUP: begin pend_q <= OP_ERASE; out_q <= OUT_OFF; end
          CMD_STATUS:   out_q <= OUT_STATUS;
          CMD_RD_GO: if (pend_q == OP_READ) begin
            pend_q <= OP_NONE; out_q <= OUT_ARRAY;
          end
          CMD_PG_GO: if (pend_q == OP_PROG)  pend_q <= OP_NONE;
          CMD_ER_GO: if (pend_q == OP_ERASE) pend_q <= OP_NONE;
          default: ;
        endcase
      end else if (ce_rise && !busy) begin
        out_q <= OUT_OFF;
      end
      if (rd_arr) io_o <= rd_data_i;
      else if (re_fall && !ce_n_s && out_q == OUT_STATUS) io_o <= status;
    end
  end

  assign io_oe_o   = ~ce_n_s & ~re_n_s & (out_q != OUT_OFF);
  assign rb_n_o    = ~busy;
  assign standby_o = ce_n_s & ~busy;
endmodule

// File: rtl/nand_fe_chk.sv
module nand_fe_chk import nand_fe_pkg::*; (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_oe_o,
  input logic        ce_n_s,
  input logic        re_n_s,
  input logic        standby_o,
  input logic        rb_n_o,
  input logic [1:0]  addr_cnt,
  input logic        adr_wr,
  input logic [23:0] addr_o,
  input logic [7:0]  col_o,
  input logic        re_fall,
  input out_e        out_q,
  input logic        busy,
  input logic        we_rise,
  input logic        cle_s,
  input logic [7:0]  io_s,
  input logic [7:0]  cmd_o,
  input logic        din_valid_o
);
  assert_oe_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> (!ce_n_s && !re_n_s));

  assert_standby_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> rb_n_o);

  assert_extra_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adr_wr && addr_cnt == 2'd3) |=> $stable(addr_o));

  assert_col_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_fall && !ce_n_s && !busy && out_q == OUT_ARRAY) |=> (col_o == $past(col_o) + 8'd1));

  assert_busy_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we_rise && !ce_n_s && cle_s && io_s != CMD_STATUS) |=> $stable(cmd_o));

  assert_din_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_valid_o |=> !din_valid_o);
endmodule

bind nand_bus_frontend nand_fe_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_oe_o    (io_oe_o),
  .ce_n_s     (ce_n_s),
  .re_n_s     (re_n_s),
  .standby_o  (standby_o),
  .rb_n_o     (rb_n_o),
  .addr_cnt   (addr_cnt),
  .adr_wr     (adr_wr),
  .addr_o     (addr_o),
  .col_o      (col_o),
  .re_fall    (re_fall),
  .out_q      (out_q),
  .busy       (busy),
  .we_rise    (we_rise),
  .cle_s      (cle_s),
  .io_s       (io_s),
  .cmd_o      (cmd_o),
  .din_valid_o(din_valid_o)
);

// File: tb/test_nand_bus_frontend.sv
module test_nand_bus_frontend;
  localparam int BRD = 20;
  localparam int BPG = 60;
  localparam int BER = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io = '0;
  logic [7:0] io_o, cmd, col, din, rd_data;
  logic [23:0] addr;
  logic io_oe, rb_n, standby, din_valid;

  always #10 clk = ~clk;

  assign rd_data = col ^ 8'h5A;

  nand_bus_frontend #(.BUSY_RD(BRD), .BUSY_PG(BPG), .BUSY_ER(BER)) i_nand_bus_frontend (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .cle_i(cle), .ale_i(ale),
    .we_n_i(we_n), .re_n_i(re_n), .wp_n_i(wp_n), .io_i(io), .io_o(io_o),
    .io_oe_o(io_oe), .rb_n_o(rb_n), .standby_o(standby), .cmd_o(cmd),
    .addr_o(addr), .col_o(col), .rd_data_i(rd_data), .din_o(din),
    .din_valid_o(din_valid)
  );

  int checks = 0, errors = 0;
  int bcnt = 0, din_cnt = 0;
  logic [7:0] din_last = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       sample_ev;
  bit         done = 1'b0;

  always @(posedge clk) begin
    if (rst_n && !rb_n) bcnt++;
    if (rst_n && din_valid) begin din_cnt++; din_last = din; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty", 0, 1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(io_oe === 1'b1, {t, " oe"}, int'(io_oe), 1);
        check(io_o === e, t, int'(io_o), int'(e));
      end
    end
  end

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; io = b; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    @(negedge clk);
    re_n = 1'b0;
    repeat (5) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->sample_ev;
    repeat (1) @(negedge clk);
    re_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!rb_n && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rb_n === 1'b1, "R1 rb_n", int'(rb_n), 1);
    check(io_oe === 1'b0, "R1 io_oe", int'(io_oe), 0);
    check(cmd === 8'h00 && addr === 24'h0 && col === 8'h00, "R1 regs", int'(addr), 0);
    check(din_valid === 1'b0, "R1 din_valid", int'(din_valid), 0);
    check(standby === 1'b1, "R1 standby", int'(standby), 1);

    ce_n = 1'b0;
    repeat (4) @(negedge clk);
    // R2 command capture
    wr(1'b1, 1'b0, 8'h5C);
    check(cmd === 8'h5C, "R2 cmd", int'(cmd), 'h5C);
    wr(1'b1, 1'b0, 8'h00);
    check(cmd === 8'h00, "R2 read setup", int'(cmd), 0);

    // R3 address order and fourth byte ignored
    wr(1'b0, 1'b1, 8'h10);
    wr(1'b0, 1'b1, 8'h22);
    wr(1'b0, 1'b1, 8'h03);
    wr(1'b0, 1'b1, 8'h77);
    check(addr === 24'h032210, "R3 addr", int'(addr), 'h032210);
    check(col === 8'h10, "R3 col", int'(col), 'h10);

    // R9 read busy, R5 array reads
    bcnt = 0;
    wr(1'b1, 1'b0, 8'h30);
    check(rb_n === 1'b0, "R9 read busy", int'(rb_n), 0);
    wait_ready();
    repeat (2) @(negedge clk);
    check(bcnt == BRD, "R9 read duration", bcnt, BRD);
    rd(8'h4A, "R5 byte0");
    rd(8'h4B, "R5 byte1");
    rd(8'h48, "R5 byte2");
    check(col === 8'h13, "R5 col", int'(col), 'h13);
    check(io_oe === 1'b0, "R6 oe after re high", int'(io_oe), 0);

    // R7 deselect while idle
    ce_n = 1'b1;
    repeat (5) @(negedge clk);
    check(standby === 1'b1, "R7 standby", int'(standby), 1);
    ce_n = 1'b0;
    repeat (4) @(negedge clk);
    re_n = 1'b0;
    repeat (5) @(negedge clk);
    check(io_oe === 1'b0, "R7 read ended", int'(io_oe), 0);
    check(col === 8'h13, "R7 col held", int'(col), 'h13);
    re_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 command restarts address count
    wr(1'b1, 1'b0, 8'h80);
    wr(1'b0, 1'b1, 8'h01);
    wr(1'b1, 1'b0, 8'h80);
    wr(1'b0, 1'b1, 8'h05);
    wr(1'b0, 1'b1, 8'h06);
    wr(1'b0, 1'b1, 8'h07);
    check(addr === 24'h070605, "R3 restart", int'(addr), 'h070605);

    // R4 data input
    wr(1'b0, 1'b0, 8'hC3);
    check(din_cnt == 1 && din_last === 8'hC3, "R4 din0", int'(din_last), 'hC3);
    check(col === 8'h06, "R4 col", int'(col), 'h06);
    wr(1'b0, 1'b0, 8'h3C);
    check(din_cnt == 2 && din_last === 8'h3C, "R4 din1", int'(din_last), 'h3C);

    // R12 protected confirm
    wp_n = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b1, 1'b0, 8'h10);
    check(cmd === 8'h10, "R12 cmd taken", int'(cmd), 'h10);
    check(rb_n === 1'b1, "R12 no busy", int'(rb_n), 1);
    wp_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 program duration
    wr(1'b1, 1'b0, 8'h80);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b0, 1'b1, 8'h01);
    wr(1'b0, 1'b1, 8'h00);
    bcnt = 0;
    wr(1'b1, 1'b0, 8'h10);
    wait_ready();
    repeat (2) @(negedge clk);
    check(bcnt == BPG, "R9 program duration", bcnt, BPG);

    // R12 abort on write protect
    wr(1'b1, 1'b0, 8'h80);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b1, 1'b0, 8'h10);
    check(rb_n === 1'b0, "R12 busy before wp", int'(rb_n), 0);
    wp_n = 1'b0;
    repeat (6) @(negedge clk);
    check(rb_n === 1'b1, "R12 abort", int'(rb_n), 1);
    wp_n = 1'b1;
    repeat (4) @(negedge clk);

    // erase: R10, R11, R8, R9
    wr(1'b1, 1'b0, 8'h60);
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b0, 1'b1, 8'h02);
    wr(1'b0, 1'b1, 8'h00);
    bcnt = 0;
    wr(1'b1, 1'b0, 8'hD0);
    check(cmd === 8'hD0 && rb_n === 1'b0, "R9 erase start", int'(cmd), 'hD0);
    wr(1'b1, 1'b0, 8'h00);
    check(cmd === 8'hD0, "R10 ignored while busy", int'(cmd), 'hD0);
    wr(1'b1, 1'b0, 8'h70);
    check(cmd === 8'h70, "R10 status while busy", int'(cmd), 'h70);
    rd(8'h80, "R11 status busy");
    ce_n = 1'b1;
    repeat (5) @(negedge clk);
    check(standby === 1'b0, "R8 no standby", int'(standby), 0);
    check(rb_n === 1'b0, "R8 still busy", int'(rb_n), 0);
    ce_n = 1'b0;
    wait_ready();
    repeat (2) @(negedge clk);
    check(bcnt == BER, "R9 erase duration", bcnt, BER);
    rd(8'hC0, "R11 status ready");
    wp_n = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h40, "R11 status protected");
    wp_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 writes while deselected
    ce_n = 1'b1;
    repeat (5) @(negedge clk);
    check(standby === 1'b1, "R7 standby after busy", int'(standby), 1);
    wr(1'b1, 1'b0, 8'h60);
    check(cmd === 8'h70, "R13 ignored deselected", int'(cmd), 'h70);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule